// File: doc/BRIEF.md
# Pin Function Multiplexer Register Bank

This block controls one bank of I/O pads. Each pin is owned either by the general-purpose I/O logic or by one of four peripheral functions, called A, B, C and D. The block keeps the per-pin state for GPIO ownership, output enable, output data, pull-up, pull-down, multi-drive (open-drain) and interrupt enable. It drives the pad output, pad output-enable and pull controls. It registers the pad input once and hands that sampled level both to a status register and to the peripheral that owns the pin.

Software reaches the block over a simple register bus. The bus has a strobe, a write flag, a word address and data as wide as the bank. Every on/off state has one address that sets the written 1 bits and another that clears them, so pins can be changed without a read-modify-write. The peripheral choice is a 2-bit code per pin. Its two bits live in two plain read/write selection registers.

Top module: `padmux_bank`

## Requirements
- R1: After reset, every pin is GPIO-owned, with output enable off, output data 0, pull-up on, pull-down off, multi-drive off, interrupt enable off and both selection registers 0 (function A).
- R2: The ownership, output-enable, data, pull-up, pull-down, multi-drive and interrupt-enable states each have a set address and a clear address. The word addresses are: ownership 0/1, output enable 4/5, data 8/9, pull-up 12/13, pull-down 16/17, multi-drive 20/21, interrupt enable 24/25. A 1 bit sets or clears that pin, and a 0 bit leaves it unchanged. Each state reads back at the word address two above its set address.
- R3: A write to the pull-down set address also turns off the pull-up of every pin written with 1.
- R4: Selection registers 0 and 1 sit at word addresses 28 and 29 and read back as written. A pin's function code is {sel1[i], sel0[i]}, where 0 means A, 1 means B, 2 means C and 3 means D.
- R5: On a GPIO-owned pin without multi-drive, pad_out follows the data bit and pad_oe follows the output-enable bit.
- R6: On a peripheral-owned pin, the output value and enable come from fn_out and fn_oe of the selected function k (bit k*NPINS+i). fn_in bit k*NPINS+i carries the sampled pad level only when pin i is peripheral-owned with code k, and is 0 otherwise.
- R7: With multi-drive on, pad_out is 0 and pad_oe is 1 only while the pin's drive is enabled and its output value is 0.
- R8: Word address 30 returns the pad level sampled on the previous clock edge, for every pin, whatever its owner.
- R9: Word address 2 returns 1 for each GPIO-owned pin and 0 for each peripheral-owned pin.
- R10: A write takes effect on the clock edge at which the strobe is seen. Read data appears on bus_rdata after that edge and is 0 after any cycle without a read. Addresses 3, 7, 11, 15, 19, 23, 27 and 31 read 0 and ignore writes.
- R11: pad_pu and pad_pd always equal the pull-up and pull-down states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, one cycle after the strobe |
| pad_in | input | NPINS | Level seen at each pad |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad driver enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| fn_out | input | 4*NPINS | Peripheral output values, function k at bits k*NPINS up |
| fn_oe | input | 4*NPINS | Peripheral output enables, same layout |
| fn_in | output | 4*NPINS | Sampled pad level routed to the owning function |

## Verification
The bench builds the block with its defaults, NPINS=32 and AW=5. Full 32-bit masks therefore reach every pin, and the 5-bit address space includes every mapped and every unmapped word. With 32 pins, one pattern can cover all four function codes and mix GPIO-owned, peripheral-owned and open-drain pins. A behavioural model checks each of these pins on every clock, alongside directed reads of each status word.

// File: rtl/padmux_bank.sv
module padmux_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_pu,
  output logic [NPINS-1:0]   pad_pd,
  input  logic [4*NPINS-1:0] fn_out,
  input  logic [4*NPINS-1:0] fn_oe,
  output logic [4*NPINS-1:0] fn_in
);

  localparam logic [AW-1:0] A_OWN_S = AW'(0),  A_OWN_C = AW'(1),  A_OWN_R = AW'(2);
  localparam logic [AW-1:0] A_OE_S  = AW'(4),  A_OE_C  = AW'(5),  A_OE_R  = AW'(6);
  localparam logic [AW-1:0] A_DAT_S = AW'(8),  A_DAT_C = AW'(9),  A_DAT_R = AW'(10);
  localparam logic [AW-1:0] A_PU_S  = AW'(12), A_PU_C  = AW'(13), A_PU_R  = AW'(14);
  localparam logic [AW-1:0] A_PD_S  = AW'(16), A_PD_C  = AW'(17), A_PD_R  = AW'(18);
  localparam logic [AW-1:0] A_MD_S  = AW'(20), A_MD_C  = AW'(21), A_MD_R  = AW'(22);
  localparam logic [AW-1:0] A_IE_S  = AW'(24), A_IE_C  = AW'(25), A_IE_R  = AW'(26);
  localparam logic [AW-1:0] A_SEL0  = AW'(28), A_SEL1  = AW'(29), A_PAD   = AW'(30);

  logic [NPINS-1:0] own_q, oe_q, dat_q, pu_q, pd_q, md_q, ie_q, sel0_q, sel1_q, pad_q;
  logic [NPINS-1:0] rd_mux, rdata_q;
  logic             wr_en, rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '1;
      oe_q   <= '0;
      dat_q  <= '0;
      pu_q   <= '1;
      pd_q   <= '0;
      md_q   <= '0;
      ie_q   <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_OWN_S: own_q  <= own_q | bus_wdata;
        A_OWN_C: own_q  <= own_q & ~bus_wdata;
        A_OE_S:  oe_q   <= oe_q | bus_wdata;
        A_OE_C:  oe_q   <= oe_q & ~bus_wdata;
        A_DAT_S: dat_q  <= dat_q | bus_wdata;
        A_DAT_C: dat_q  <= dat_q & ~bus_wdata;
        A_PU_S:  pu_q   <= pu_q | bus_wdata;
        A_PU_C:  pu_q   <= pu_q & ~bus_wdata;
        A_PD_S: begin
          pd_q <= pd_q | bus_wdata;
          pu_q <= pu_q & ~bus_wdata;
        end
        A_PD_C:  pd_q   <= pd_q & ~bus_wdata;
        A_MD_S:  md_q   <= md_q | bus_wdata;
        A_MD_C:  md_q   <= md_q & ~bus_wdata;
        A_IE_S:  ie_q   <= ie_q | bus_wdata;
        A_IE_C:  ie_q   <= ie_q & ~bus_wdata;
        A_SEL0:  sel0_q <= bus_wdata;
        A_SEL1:  sel1_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_OWN_R: rd_mux = own_q;
      A_OE_R:  rd_mux = oe_q;
      A_DAT_R: rd_mux = dat_q;
      A_PU_R:  rd_mux = pu_q;
      A_PD_R:  rd_mux = pd_q;
      A_MD_R:  rd_mux = md_q;
      A_IE_R:  rd_mux = ie_q;
      A_SEL0:  rd_mux = sel0_q;
      A_SEL1:  rd_mux = sel1_q;
      A_PAD:   rd_mux = pad_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      pad_q   <= '0;
    end else begin
      rdata_q <= rd_en ? rd_mux : '0;
      pad_q   <= pad_in;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_pu    = pu_q;
  assign pad_pd    = pd_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] code;
    logic       val, en;
    assign code = {sel1_q[i], sel0_q[i]};
    assign val  = own_q[i] ? dat_q[i] : fn_out[int'(code)*NPINS + i];
    assign en   = own_q[i] ? oe_q[i]  : fn_oe[int'(code)*NPINS + i];
    assign pad_out[i] = md_q[i] ? 1'b0 : val;
    assign pad_oe[i]  = md_q[i] ? (en & ~val) : en;
    for (genvar k = 0; k < 4; k++) begin : g_fn
      assign fn_in[k*NPINS + i] = ~own_q[i] & (code == 2'(k)) & pad_q[i];
    end
  end

endmodule

// File: rtl/padmux_bank_chk.sv
module padmux_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [NPINS-1:0]   bus_wdata,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_pu,
  input logic [NPINS-1:0]   oe_q,
  input logic [NPINS-1:0]   dat_q,
  input logic [NPINS-1:0]   md_q,
  input logic [NPINS-1:0]   own_q,
  input logic [4*NPINS-1:0] fn_in
);

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(4)) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_OE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(5)) |=> ((oe_q & $past(bus_wdata)) == '0)); // R2

  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (bus_addr == AW'(8) || bus_addr == AW'(9))) |=> $stable(dat_q)); // R2

  AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(16)) |=> ((pad_pu & $past(bus_wdata)) == '0)); // R3

  AST_OWN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'(1)) |=> ((own_q & $past(bus_wdata)) == '0)); // R9

  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & md_q) == '0)); // R7

  for (genvar k = 0; k < 4; k++) begin : g_fnchk
    AST_FN_GPIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((fn_in[k*NPINS +: NPINS] & own_q) == '0)); // R6
  end

  AST_FN_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fn_in[0], fn_in[NPINS], fn_in[2*NPINS], fn_in[3*NPINS]})); // R6

endmodule

bind padmux_bank padmux_bank_chk #(.NPINS(NPINS), .AW(AW)) chk_i (.*);

// File: tb/padmux_bank_tb_top.sv
`timescale 1ns/1ps
module padmux_bank_tb_top;
  localparam int N  = 32;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [4*N-1:0] fn_out = '0, fn_oe = '0, fn_in;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  padmux_bank #(.NPINS(N), .AW(AW)) dut_i (.*);

  // behavioural reference
  logic [N-1:0] m_own, m_oe, m_dat, m_pu, m_pd, m_md, m_ie, m_s0, m_s1, m_pad, m_rd;

  function automatic logic [N-1:0] m_read(input int a);
    case (a)
      2: return m_own;   6: return m_oe;   10: return m_dat; 14: return m_pu;
      18: return m_pd;   22: return m_md;  26: return m_ie;  28: return m_s0;
      29: return m_s1;   30: return m_pad;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = '1; m_oe = '0; m_dat = '0; m_pu = '1; m_pd = '0;
      m_md = '0; m_ie = '0; m_s0 = '0; m_s1 = '0; m_pad = '0; m_rd = '0;
    end else begin
      m_rd  = (bus_sel && !bus_wr) ? m_read(int'(bus_addr)) : '0;
      m_pad = pad_in;
      if (bus_sel && bus_wr) begin
        case (int'(bus_addr))
          0: m_own |= bus_wdata;   1: m_own &= ~bus_wdata;
          4: m_oe  |= bus_wdata;   5: m_oe  &= ~bus_wdata;
          8: m_dat |= bus_wdata;   9: m_dat &= ~bus_wdata;
          12: m_pu |= bus_wdata;   13: m_pu &= ~bus_wdata;
          16: begin m_pd |= bus_wdata; m_pu &= ~bus_wdata; end
          17: m_pd &= ~bus_wdata;
          20: m_md |= bus_wdata;   21: m_md &= ~bus_wdata;
          24: m_ie |= bus_wdata;   25: m_ie &= ~bus_wdata;
          28: m_s0 = bus_wdata;    29: m_s1 = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [4*N-1:0] act, input logic [4*N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] eo, ee;
      logic [4*N-1:0] efi;
      efi = '0;
      for (int i = 0; i < N; i++) begin
        int c;
        logic v, e;
        c = 2 * int'(m_s1[i]) + int'(m_s0[i]);
        v = m_own[i] ? m_dat[i] : fn_out[c*N+i];
        e = m_own[i] ? m_oe[i]  : fn_oe[c*N+i];
        if (m_md[i]) begin eo[i] = 1'b0; ee[i] = e && !v; end
        else begin eo[i] = v; ee[i] = e; end
        if (!m_own[i]) efi[c*N+i] = m_pad[i];
      end
      check(pad_out == eo, "R5/R6/R7 pad_out", {96'b0, pad_out}, {96'b0, eo});
      check(pad_oe == ee, "R5/R6/R7 pad_oe", {96'b0, pad_oe}, {96'b0, ee});
      check(pad_pu == m_pu && pad_pd == m_pd, "R11 pulls", {64'b0, pad_pu, pad_pd}, {64'b0, m_pu, m_pd});
      check(fn_in == efi, "R6 fn_in", fn_in, efi);
      check(bus_rdata == m_rd, "R10 rdata", {96'b0, bus_rdata}, {96'b0, m_rd});
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, input logic [N-1:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 0;
    check(bus_rdata == exp, req, {96'b0, bus_rdata}, {96'b0, exp});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2, '1, "R1 own");  rd(6, '0, "R1 oe");  rd(10, '0, "R1 dat");
    rd(14, '1, "R1 pu");  rd(18, '0, "R1 pd"); rd(22, '0, "R1 md");
    rd(26, '0, "R1 ie");  rd(28, '0, "R1 sel0"); rd(29, '0, "R1 sel1");
    // R2 set/clear
    wr(4, 32'h0000_00FF); wr(8, 32'h0000_005A);
    rd(6, 32'h0000_00FF, "R2 oe set"); rd(10, 32'h0000_005A, "R2 dat set");
    wr(9, 32'h0000_000A); wr(8, 32'h0);
    rd(10, 32'h0000_0050, "R2 dat clr zero-bits kept");
    wr(24, 32'h8000_0001); wr(25, 32'h0000_0001);
    rd(26, 32'h8000_0000, "R2 ie");
    // R3
    wr(16, 32'h0000_0003);
    rd(14, 32'hFFFF_FFFC, "R3 pu forced off"); rd(18, 32'h3, "R3 pd");
    wr(17, 32'h1); wr(12, 32'h1);
    rd(14, 32'hFFFF_FFFD, "R2 pu set");
    // R4 select codes
    wr(28, 32'h0000_F0F0); wr(29, 32'h0000_FF00);
    rd(28, 32'h0000_F0F0, "R4 sel0"); rd(29, 32'h0000_FF00, "R4 sel1");
    // R6 peripheral ownership
    @(negedge clk);
    fn_out = {32'hAAAA_5555, 32'h0F0F_F0F0, 32'h3333_CCCC, 32'h00FF_FF00};
    fn_oe  = {32'hFFFF_0000, 32'h0000_FFFF, 32'hF0F0_0F0F, 32'h5A5A_A5A5};
    wr(1, 32'h0000_FFFF);
    rd(2, 32'hFFFF_0000, "R9 own status");
    // R8 pad sampling
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(30, 32'hDEAD_BEEF, "R8 pad read");
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk);
    rd(30, 32'h1234_5678, "R8 pad read 2");
    // R7 open drain on GPIO and peripheral pins
    wr(20, 32'h00F0_00FF);
    wr(4, 32'h00FF_0000); wr(8, 32'h0050_0000);
    rd(22, 32'h00F0_00FF, "R7 md status");
    wr(21, 32'h00F0_00FF);
    // R10 unmapped
    wr(31, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
    rd(3, '0, "R10 unmapped read"); rd(31, '0, "R10 unmapped read 2");
    rd(2, 32'hFFFF_0000, "R10 write ignored");
    wr(0, 32'h0000_00F0);
    rd(2, 32'hFFFF_00F0, "R9 own set");
    // random traffic against model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      bus_sel   = ($urandom % 3) != 0;
      bus_wr    = $urandom % 2;
      bus_addr  = AW'($urandom % 32);
      bus_wdata = $urandom;
      pad_in    = $urandom;
      if (n % 8 == 0) begin
        fn_out = {$urandom, $urandom, $urandom, $urandom};
        fn_oe  = {$urandom, $urandom, $urandom, $urandom};
      end
    end
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule